// File: doc/BRIEF.md
# Wear-Margin Supply Voltage Stepper

This block steers a supply-voltage setpoint so that the predicted worst-case end-of-life threshold shift of a device population stays inside its budget. Upstream logic does the curve fitting and statistics. It delivers one worst-case shift value (a mean-plus-three-sigma bound over 32 monitored sensors) together with a valid pulse. A separate level says whether every monitored sensor currently has a usable fit. The block also counts per-sample strobes, so that it knows when enough fresh data has accumulated to trust the next prediction.

On each permitted evaluation, the block compares the prediction with a programmable limit. If the prediction is above the limit, the setpoint moves down by one 100 mV code step. If it is below the limit, the setpoint moves up by one step. If the two are equal, nothing happens. The setpoint is clamped to programmable minimum and maximum codes.

No evaluation is allowed until a warm-up window of samples has been seen after reset. After every actual setpoint move, evaluation is also blocked until a hold-off number of new samples has arrived.

Top module: `wear_vstep_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first decision, `vcode_o` equals DEFAULT_CODE and `eval_enable_o` is 0.
- R2: `eval_enable_o` stays 0 until WARMUP `sample_valid_i` strobes have been taken since reset. It is 1 in the cycle after the strobe that reaches WARMUP, provided the hold-off condition of R7 is also met.
- R3: When `eval_enable_o`, `pred_valid_i` and `all_ready_i` are all 1 and `pred_shift_i > shift_limit_i`, `vcode_o` is one less in the next cycle, unless it is already at or below `vmin_code_i`.
- R4: Under the same enables with `pred_shift_i < shift_limit_i`, `vcode_o` is one more in the next cycle, unless it is already at or above `vmax_code_i`.
- R5: Under the same enables with `pred_shift_i == shift_limit_i`, `vcode_o` does not change and `eval_enable_o` stays 1.
- R6: A decision blocked by the min or max code leaves `vcode_o` unchanged and does not restart the hold-off; `eval_enable_o` stays 1.
- R7: After every change of `vcode_o`, `eval_enable_o` is 0 from the next cycle until HOLDOFF further `sample_valid_i` strobes have been taken. A strobe in the same cycle as the change is not counted.
- R8: A prediction presented while `eval_enable_o` is 0 or `all_ready_i` is 0 has no effect on `vcode_o`.
- R9: `vcode_o` never moves by more than one code per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | One pulse per new sensor sample |
| pred_valid_i | input | 1 | Prediction on `pred_shift_i` is valid this cycle |
| pred_shift_i | input | SHIFT_W | Predicted worst-case end-of-life shift |
| all_ready_i | input | 1 | Every monitored sensor has a valid fit |
| shift_limit_i | input | SHIFT_W | Maximum allowed shift |
| vmin_code_i | input | CODE_W | Lowest permitted setpoint code |
| vmax_code_i | input | CODE_W | Highest permitted setpoint code |
| vcode_o | output | CODE_W | Setpoint code in 100 mV units |
| eval_enable_o | output | 1 | A new evaluation is permitted |

## Verification
The bench builds the block with WARMUP=12, HOLDOFF=5, CODE_W=4 and DEFAULT_CODE=7, instead of the 200/100 window lengths. With these values, the warm-up edge, many hold-off windows and both saturation bounds all fall within a few thousand cycles. The 4-bit code and a narrow min/max band let random runs of up and down decisions reach both clamps often. Small prediction offsets around the limit make the equal case common.

// File: rtl/wear_vstep_pkg.sv
package wear_vstep_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/sample_gate.sv
module sample_gate #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          full;

  assign full   = (cnt_q == CW'(LIMIT));
  assign done_o = full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (tick_i && !full) cnt_q <= cnt_q + 1'b1;
  end

  // R2 R7: counter saturates at its limit
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));

  a_r7_clear_drops_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !done_o);
endmodule

// File: rtl/step_decider.sv
module step_decider
  import wear_vstep_pkg::*;
#(
  parameter int unsigned SHIFT_W = 12
) (
  input  logic               fire_i,
  input  logic [SHIFT_W-1:0] pred_i,
  input  logic [SHIFT_W-1:0] limit_i,
  output step_e              step_o
);
  always_comb begin
    step_o = STEP_HOLD;
    if (fire_i) begin
      if (pred_i > limit_i)      step_o = STEP_DOWN;
      else if (pred_i < limit_i) step_o = STEP_UP;
    end
  end
endmodule

// File: rtl/setpoint_reg.sv
module setpoint_reg
  import wear_vstep_pkg::*;
#(
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned DEFAULT_CODE = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  input  logic [CODE_W-1:0] vmin_i,
  input  logic [CODE_W-1:0] vmax_i,
  output logic [CODE_W-1:0] code_o,
  output logic              changed_o
);
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    unique case (step_i)
      STEP_UP:   if (code_q < vmax_i) code_d = code_q + 1'b1;
      STEP_DOWN: if (code_q > vmin_i) code_d = code_q - 1'b1;
      default:   code_d = code_q;
    endcase
  end

  assign changed_o = (code_d != code_q);
  assign code_o    = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_W'(DEFAULT_CODE);
    else         code_q <= code_d;
  end

  // R6: clamped moves leave the code alone
  a_r6_upper_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_UP && code_q >= vmax_i) |=> $stable(code_q));
  a_r6_lower_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_DOWN && code_q <= vmin_i) |=> $stable(code_q));
  // R3 R4: direction follows the step
  a_r3_down_moves_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_DOWN && code_q > vmin_i) |=> (code_q == $past(code_q) - 1'b1));
  a_r4_up_moves_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_UP && code_q < vmax_i) |=> (code_q == $past(code_q) + 1'b1));
endmodule

// File: rtl/wear_vstep_ctrl.sv
module wear_vstep_ctrl
  import wear_vstep_pkg::*;
#(
  parameter int unsigned SHIFT_W      = 12,
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned WARMUP       = 200,
  parameter int unsigned HOLDOFF      = 100,
  parameter int unsigned DEFAULT_CODE = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic               pred_valid_i,
  input  logic [SHIFT_W-1:0] pred_shift_i,
  input  logic               all_ready_i,
  input  logic [SHIFT_W-1:0] shift_limit_i,
  input  logic [CODE_W-1:0]  vmin_code_i,
  input  logic [CODE_W-1:0]  vmax_code_i,
  output logic [CODE_W-1:0]  vcode_o,
  output logic               eval_enable_o
);
  logic  warm_done, hold_done, fire, changed;
  step_e step;

  sample_gate #(.LIMIT(WARMUP)) u_warm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (1'b0),
    .tick_i  (sample_valid_i),
    .done_o  (warm_done)
  );

  // hold-off restarts on every real move; strobe in that cycle is dropped
  sample_gate #(.LIMIT(HOLDOFF)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (changed),
    .tick_i  (sample_valid_i),
    .done_o  (hold_done)
  );

  assign eval_enable_o = warm_done & hold_done;
  assign fire          = eval_enable_o & pred_valid_i & all_ready_i;

  step_decider #(.SHIFT_W(SHIFT_W)) u_dec (
    .fire_i  (fire),
    .pred_i  (pred_shift_i),
    .limit_i (shift_limit_i),
    .step_o  (step)
  );

  setpoint_reg #(.CODE_W(CODE_W), .DEFAULT_CODE(DEFAULT_CODE)) u_set (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .vmin_i    (vmin_code_i),
    .vmax_i    (vmax_code_i),
    .code_o    (vcode_o),
    .changed_o (changed)
  );

  a_r8_no_fire_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eval_enable_o && pred_valid_i && all_ready_i) |=> $stable(vcode_o));
  a_r7_move_blocks_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcode_o != $past(vcode_o)) |-> !eval_enable_o);
  a_r5_equal_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_enable_o && pred_valid_i && all_ready_i && pred_shift_i == shift_limit_i)
      |=> ($stable(vcode_o) && eval_enable_o));
  a_r9_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vcode_o == $past(vcode_o) || vcode_o == $past(vcode_o) + 1'b1 ||
              vcode_o == $past(vcode_o) - 1'b1));
endmodule

// File: tb/tb_wear_vstep_ctrl.sv
module tb_wear_vstep_ctrl;
  localparam int SW = 12, CW = 4, W = 12, H = 5, DEF = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sv = 0, pv = 0, rdy = 0;
  logic [SW-1:0] pred = '0, lim = 12'd100;
  logic [CW-1:0] vmin = 4'd3, vmax = 4'd11;
  logic [CW-1:0] vcode;
  logic eval_en;

  int checks = 0, errors = 0, cyc = 0;
  int m_code = DEF, m_warm = 0, m_hold = 0;

  always #2 clk = ~clk;

  wear_vstep_ctrl #(.SHIFT_W(SW), .CODE_W(CW), .WARMUP(W), .HOLDOFF(H),
                    .DEFAULT_CODE(DEF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sv), .pred_valid_i(pv),
    .pred_shift_i(pred), .all_ready_i(rdy), .shift_limit_i(lim),
    .vmin_code_i(vmin), .vmax_code_i(vmax), .vcode_o(vcode), .eval_enable_o(eval_en));

  function automatic int m_eval();
    return (m_warm >= W && m_hold >= H) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic drive(logic s, logic p, logic r, int pr);
    sv = s; pv = p; rdy = r; pred = SW'(pr);
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic cycle(string req);
    bit moved;
    @(posedge clk);
    moved = 0;
    if (pv && rdy && m_eval() == 1) begin
      if (pred > lim && m_code > int'(vmin)) begin m_code--; moved = 1; end
      else if (pred < lim && m_code < int'(vmax)) begin m_code++; moved = 1; end
    end
    if (moved) m_hold = 0;
    else if (sv && m_hold < H) m_hold++;
    if (sv && m_warm < W) m_warm++;
    @(negedge clk);
    chk(req, int'(vcode), m_code);
    chk(req, int'(eval_en), m_eval());
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", int'(vcode), DEF);
    chk("R1", int'(eval_en), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", int'(vcode), DEF);
    chk("R1", int'(eval_en), 0);

    // warm-up: predictions ignored while disabled
    for (int i = 0; i < W - 1; i++) begin
      drive(1, 1, 1, 50);
      cycle("R8");
    end
    chk("R2", int'(eval_en), 0);
    chk("R8", int'(vcode), DEF);
    drive(1, 0, 1, 50);
    cycle("R2");
    chk("R2", int'(eval_en), 1);

    drive(0, 1, 0, 150);
    cycle("R8");
    chk("R8", int'(vcode), DEF);

    drive(1, 1, 1, 150);
    cycle("R3");
    chk("R3", int'(vcode), DEF - 1);
    chk("R7", int'(eval_en), 0);
    for (int i = 0; i < H - 1; i++) begin
      drive(1, 1, 1, 150);
      cycle("R7");
    end
    chk("R7", int'(eval_en), 0);
    chk("R7", int'(vcode), DEF - 1);
    drive(1, 1, 1, 150);
    cycle("R7");
    chk("R7", int'(eval_en), 1);
    chk("R7", int'(vcode), DEF - 1);

    drive(0, 1, 1, 100);
    cycle("R5");
    chk("R5", int'(vcode), DEF - 1);
    chk("R5", int'(eval_en), 1);

    drive(0, 1, 1, 20);
    cycle("R4");
    chk("R4", int'(vcode), DEF);
    chk("R7", int'(eval_en), 0);
    for (int i = 0; i < H; i++) begin
      drive(1, 0, 1, 0);
      cycle("R7");
    end
    chk("R7", int'(eval_en), 1);

    vmax = 4'(DEF);
    drive(0, 1, 1, 20);
    cycle("R6");
    chk("R6", int'(vcode), DEF);
    chk("R6", int'(eval_en), 1);
    vmin = 4'(DEF);
    drive(0, 1, 1, 200);
    cycle("R6");
    chk("R6", int'(vcode), DEF);
    chk("R6", int'(eval_en), 1);

    vmin = 4'd3; vmax = 4'd11;
    for (int i = 0; i < 4000; i++) begin
      int off = int'($urandom % 5) - 2;
      int bias = ((i / 400) % 2 == 0) ? -4 : 4;
      if ($urandom % 4 == 0) bias = 0;
      drive(1'($urandom % 2), 1'($urandom % 3 == 0), 1'($urandom % 4 != 0),
            100 + off + bias);
      cycle("R3 R4 R6 R7 R9");
    end

    drive(0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule